// File: doc/BRIEF.md
# Ethernet Transmit Serializer

This block turns one frame into a serial bit stream. On a start request it sends a fixed preamble with a sync pair at the end. It then pulls bytes one at a time from a show-ahead byte FIFO and sends each one least significant bit first. Every data bit also updates a serial CRC-32 register. When the byte flagged as the end of frame has gone out, the block shifts the complemented CRC register out, most significant bit first, as the frame check sequence.

A collision input can end the frame at any bit of the preamble, the data or the FCS. The bit already on the line finishes first. The block then sends a fixed run of ones as a jam and reports the collision. If the FIFO is empty at a byte boundary before the end-of-frame byte has been read, the frame is abandoned and the block reports an underrun. Line coding and retry scheduling belong to other blocks.

Top module: `eth_tx_serializer`

## Requirements
- R1: During and after reset, `tx_en_o`, `txd_o`, `fifo_rd_o`, `done_o`, `collided_o` and `underrun_o` are all low.
- R2: A frame opens with PRE_BITS (default 62) alternating bits, starting with 1 and ending with 0, followed by two 1 bits, so 64 bits by default.
- R3: Each data byte is taken from `fifo_data_i` in the cycle where `fifo_rd_o` is high and is sent LSB first. `fifo_rd_o` is high only when `fifo_empty_i` is low. Exactly one byte is popped per byte sent.
- R4: After the byte read with `fifo_last_i` high, the block sends 32 FCS bits. These bits are the complement of a CRC-32 register (polynomial 0x04C11DB7, preset to all ones, fed with every data bit in the order sent), shifted out from bit 31 down. This is the standard Ethernet FCS.
- R5: `tx_en_o` is high from the first preamble bit through the last FCS bit and in no other cycle. `done_o` is high for exactly the one cycle after the last FCS bit.
- R6: If `col_i` is high in a cycle of the preamble, the data or the FCS, that cycle's bit still goes out. After it come exactly JAM_BITS (default 32) 1 bits, and then `tx_en_o` falls. `collided_o` is high for the one cycle after the last jam bit, and `done_o` stays low.
- R7: `col_i` has no effect while the block is idle or already sending the jam.
- R8: If a byte is needed before the end-of-frame byte and `fifo_empty_i` is high, that cycle's bit is the last one sent. `tx_en_o` then falls, `underrun_o` is high for one cycle, and no FCS follows.
- R9: `start_i` is ignored while a frame or jam is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | transmit bit clock |
| rst_n | input | 1 | active-low synchronous reset |
| start_i | input | 1 | request to send one frame |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | BYTE_W | head byte of the FIFO (show-ahead) |
| fifo_last_i | input | 1 | head byte is the last byte of the frame |
| fifo_rd_o | output | 1 | pop the head byte |
| col_i | input | 1 | collision detected |
| txd_o | output | 1 | serial transmit bit |
| tx_en_o | output | 1 | a bit is being sent |
| done_o | output | 1 | one-cycle pulse: frame sent in full |
| collided_o | output | 1 | one-cycle pulse: jam finished after a collision |
| underrun_o | output | 1 | one-cycle pulse: frame abandoned for lack of data |

## Verification
The bench uses the default parameters: a 62-bit alternating preamble, a 32-bit jam and 8-bit bytes. With these values the preamble and FCS boundaries sit at bit 64 and at 64 plus eight times the byte count. That lets collisions be placed exactly on the first bit, inside a byte, inside the FCS and on the final FCS bit. Underruns are driven both at the first byte and in the middle of a frame. The expected FCS comes from a bit-reversed CRC-32 computed in the bench. This reaches the same result as the design's forward register by a different route.

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer #(
  parameter int PRE_BITS = 62,
  parameter int JAM_BITS = 32,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  input  logic              fifo_last_i,
  output logic              fifo_rd_o,
  input  logic              col_i,
  output logic              txd_o,
  output logic              tx_en_o,
  output logic              done_o,
  output logic              collided_o,
  output logic              underrun_o
);
  localparam int FCS_BITS = 32;
  localparam int CW = $clog2(PRE_BITS + 2 + JAM_BITS + FCS_BITS);
  localparam logic [31:0] POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_FCS, S_JAM} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              last_q;
  logic [31:0]       crc;

  wire sending  = (state == S_PRE) || (state == S_DATA) || (state == S_FCS);
  wire pre_end  = (state == S_PRE)  && (cnt == CW'(PRE_BITS + 1));
  wire byte_end = (state == S_DATA) && (cnt == CW'(BYTE_W - 1));
  wire fcs_end  = (state == S_FCS)  && (cnt == CW'(FCS_BITS - 1));
  wire need     = pre_end || (byte_end && !last_q);
  wire crc_fb   = crc[31] ^ sh[0];

  assign fifo_rd_o = need && !fifo_empty_i && !col_i;
  assign tx_en_o   = (state != S_IDLE);

  always_comb begin
    case (state)
      S_PRE:   txd_o = (cnt >= CW'(PRE_BITS)) || !cnt[0];
      S_DATA:  txd_o = sh[0];
      S_FCS:   txd_o = ~crc[31];
      S_JAM:   txd_o = 1'b1;
      default: txd_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      last_q     <= 1'b0;
      crc        <= '1;
      done_o     <= 1'b0;
      collided_o <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      collided_o <= 1'b0;
      underrun_o <= 1'b0;
      if (state == S_IDLE) begin
        if (start_i) begin
          state <= S_PRE;
          cnt   <= '0;
          crc   <= '1;
        end
      end else if (state == S_JAM) begin
        if (cnt == CW'(JAM_BITS - 1)) begin
          state      <= S_IDLE;
          collided_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (col_i) begin
        state <= S_JAM;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (state == S_DATA) begin
          sh  <= sh >> 1;
          crc <= {crc[30:0], 1'b0} ^ (crc_fb ? POLY : 32'h0);
        end
        if (state == S_FCS) crc <= {crc[30:0], 1'b1};
        if (need) begin
          if (fifo_empty_i) begin
            state      <= S_IDLE;
            underrun_o <= 1'b1;
          end else begin
            state  <= S_DATA;
            cnt    <= '0;
            sh     <= fifo_data_i;
            last_q <= fifo_last_i;
          end
        end else if (byte_end) begin
          state <= S_FCS;
          cnt   <= '0;
        end else if (fcs_end) begin
          state  <= S_IDLE;
          done_o <= 1'b1;
        end
      end
    end
  end

  p_rd_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i);
  p_one_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, collided_o, underrun_o}));
  p_done_ends_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !tx_en_o && $past(tx_en_o));
  p_jam_tail_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collided_o) |-> $past(txd_o) && $past(tx_en_o));
  p_idle_col_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_o && !start_i && col_i) |=> !tx_en_o);
  p_underrun_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> !tx_en_o && !done_o);
  p_busy_sending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && start_i && !col_i && !need && !fcs_end) |=> tx_en_o);
endmodule

// File: tb/test_eth_tx_serializer.sv
module test_eth_tx_serializer;
  logic clk = 0, rst_n = 0, start_i = 0, col_i = 0;
  logic fifo_empty_i, fifo_last_i, fifo_rd_o;
  logic [7:0] fifo_data_i;
  logic txd_o, tx_en_o, done_o, collided_o, underrun_o;

  always #2 clk = ~clk;

  eth_tx_serializer i_eth_tx_serializer (.*);

  logic [7:0] fm [0:31];
  int wr_n = 0, rd_ptr = 0;
  logic eofm = 0;
  assign fifo_empty_i = (rd_ptr >= wr_n);
  assign fifo_data_i  = fm[rd_ptr[4:0]];
  assign fifo_last_i  = eofm && (rd_ptr == wr_n - 1);
  always @(posedge clk)
    if (!rst_n) rd_ptr <= 0;
    else if (fifo_rd_o && !fifo_empty_i) rd_ptr <= rd_ptr + 1;

  int total = 0, bad = 0, done_n = 0, col_n = 0, und_n = 0;
  bit exp_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en_o) begin
        if (exp_q.size() == 0) chk(0, "R5 extra bit", 1, 0);
        else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(txd_o == e, t, txd_o, e);
        end
      end
      if (done_o) done_n++;
      if (collided_o) col_n++;
      if (underrun_o) und_n++;
    end
  end

  task automatic reset_dut();
    rst_n = 0;
    start_i = 0; col_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    done_n = 0; col_n = 0; und_n = 0;
  endtask

  task automatic load(input byte unsigned b[], input bit eof);
    foreach (b[i]) fm[i] = b[i];
    wr_n = b.size();
    eofm = eof;
  endtask

  function automatic void build(input byte unsigned b[], input int nb, input bit fcs,
                                ref bit bits[$], ref string tags[$]);
    logic [31:0] c;
    bits.delete(); tags.delete();
    for (int i = 0; i < 62; i++) begin bits.push_back(~i[0]); tags.push_back("R2"); end
    bits.push_back(1); tags.push_back("R2");
    bits.push_back(1); tags.push_back("R2");
    c = '1;
    for (int i = 0; i < nb; i++)
      for (int k = 0; k < 8; k++) begin
        bit d;
        d = b[i][k];
        bits.push_back(d); tags.push_back("R3");
        c = ((c[0] ^ d) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    if (fcs) begin
      c = ~c;
      for (int k = 0; k < 32; k++) begin bits.push_back(c[k]); tags.push_back("R4"); end
    end
  endfunction

  task automatic wait_idle();
    int g = 0;
    while ((exp_q.size() != 0 || tx_en_o) && g < 2000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 missing bits", exp_q.size(), 0);
  endtask

  task automatic flags(int d, int c, int u, string req);
    chk(done_n == d, {req, " done"}, done_n, d);
    chk(col_n == c, {req, " collided"}, col_n, c);
    chk(und_n == u, {req, " underrun"}, und_n, u);
    done_n = 0; col_n = 0; und_n = 0;
  endtask

  task automatic go();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic frame(input byte unsigned b[]);
    bit bits[$];
    string tags[$];
    reset_dut();
    load(b, 1);
    build(b, b.size(), 1, bits, tags);
    exp_q = bits; tag_q = tags;
    go();
    wait_idle();
    flags(1, 0, 0, "R5");
    chk(rd_ptr == b.size(), "R3 pops", rd_ptr, b.size());
  endtask

  task automatic collide(input byte unsigned b[], input int at, input bit again);
    bit bits[$];
    string tags[$];
    reset_dut();
    load(b, 1);
    build(b, b.size(), 1, bits, tags);
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i <= at; i++) begin exp_q.push_back(bits[i]); tag_q.push_back(tags[i]); end
    for (int i = 0; i < 32; i++) begin exp_q.push_back(1); tag_q.push_back(again ? "R7 jam" : "R6 jam"); end
    go();
    while (!tx_en_o) @(negedge clk);
    repeat (at) @(negedge clk);
    col_i = 1;
    @(negedge clk) col_i = 0;
    if (again) begin
      repeat (10) @(negedge clk);
      col_i = 1;
      @(negedge clk) col_i = 0;
    end
    wait_idle();
    flags(0, 1, 0, "R6");
  endtask

  task automatic underrun(input byte unsigned b[]);
    bit bits[$];
    string tags[$];
    reset_dut();
    load(b, 0);
    build(b, b.size(), 0, bits, tags);
    exp_q = bits; tag_q = tags;
    go();
    wait_idle();
    flags(0, 0, 1, "R8");
  endtask

  initial begin
    bit bits[$];
    string tags[$];
    byte unsigned big[];
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!tx_en_o && !txd_o && !fifo_rd_o, "R1 outputs", {tx_en_o, txd_o, fifo_rd_o}, 0);
    chk(!done_o && !collided_o && !underrun_o, "R1 flags", {done_o, collided_o, underrun_o}, 0);

    frame('{8'hA5});
    frame('{8'h00, 8'hFF, 8'h12, 8'h80, 8'h01});
    big = new[16];
    foreach (big[i]) big[i] = 8'(i * 37 + 3);
    frame(big);

    collide('{8'h55, 8'h66}, 0, 0);
    collide('{8'h55, 8'h66}, 3, 0);
    collide('{8'hC3, 8'h3C, 8'h99, 8'h11}, 70, 0);
    collide('{8'hC3, 8'h3C, 8'h99, 8'h11}, 110, 0);
    collide('{8'hC3, 8'h3C, 8'h99, 8'h11}, 127, 0);
    collide('{8'h42}, 20, 1);

    underrun('{});
    underrun('{8'hDE, 8'hAD});

    // R7: collision while idle
    reset_dut();
    @(negedge clk) col_i = 1;
    @(negedge clk) col_i = 0;
    repeat (5) @(negedge clk);
    chk(!tx_en_o, "R7 idle col", tx_en_o, 0);
    flags(0, 0, 0, "R7");

    // R9: start during a frame
    reset_dut();
    load('{8'h3A, 8'h7E}, 1);
    build('{8'h3A, 8'h7E}, 2, 1, bits, tags);
    exp_q = bits; tag_q = tags;
    go();
    repeat (30) @(negedge clk);
    start_i = 1;
    @(negedge clk) start_i = 0;
    repeat (50) @(negedge clk);
    start_i = 1;
    @(negedge clk) start_i = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(!tx_en_o, "R9 no restart", tx_en_o, 0);
    flags(1, 0, 0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule